// File: doc/BRIEF.md
# Collision Backoff Delay Generator

This block times the wait a half-duplex Ethernet transmitter takes after a collision before it tries the frame again. On a start pulse it captures the retransmission attempt number, a two-bit code that selects how far the backoff exponent may grow, and the link speed. It derives the exponent, masks a pseudo-random value down to that many bits to obtain a slot count, and then counts that many slot times on a bit-time tick. At the end it pulses `done`.

While it counts, `busy` is high and further start pulses are dropped. A draw of zero, or a link in full-duplex mode, skips the wait and answers on the next clock. The drawn slot count is presented on `drawnSlots` so that the surrounding transmit logic can record it.

Top module: `collision_backoff`

## Requirements
- R1: The exponent k is min(n, 10) for limit code 0, min(n, 8) for code 1, min(n, 4) for code 2 and min(n, 1) for code 3, where n is `attempt`; every value below 2^k can be drawn.
- R2: The slot count r is drawn from a free-running 16-bit pseudo-random register masked to its low k bits, so 0 <= r < 2^k; r appears on `drawnSlots` on the clock after the accepted start and holds until the next accepted start.
- R3: One slot lasts SLOT_LO bit ticks (default 512) when `gigMode` is 0 and SLOT_HI bit ticks (default 4096) when `gigMode` is 1, the speed being captured with the start.
- R4: In half-duplex mode with r > 0, `busy` is high from the clock after start until `done`, and `done` rises on the clock edge that consumes the (r x slot)-th `bitTick` seen while busy.
- R5: In half-duplex mode with r = 0, `done` is high on the clock after start and `busy` stays low.
- R6: With `halfDuplex` at 0, `done` is high on the clock after start whatever r is, and `busy` stays low.
- R7: A start pulse that arrives while `busy` is high is ignored: `drawnSlots` and the remaining delay do not change.
- R8: `bitTick` is counted only while busy; a low `bitTick` pauses the count, and ticks while idle have no effect.
- R9: After reset `busy`, `done` and `drawnSlots` are all 0.
- R10: `done` is a one-clock pulse during which `busy` is low; `busy` falls on the same edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a backoff wait (one-clock pulse) |
| attempt | input | ATTEMPT_W | Retransmission attempt number n |
| limitCode | input | 2 | Exponent clamp select |
| gigMode | input | 1 | 1 selects the long (gigabit) slot |
| halfDuplex | input | 1 | 1 enables the wait; 0 answers at once |
| bitTick | input | 1 | One pulse per bit time |
| done | output | 1 | Retry may proceed (one-clock pulse) |
| busy | output | 1 | Wait in progress |
| drawnSlots | output | 10 (LIMIT_C0) | Slot count r of the last accepted start |

## Verification
A fault in the slot counter or the bit counter shows at the ports as a `done` that arrives a whole number of ticks early or late, visible at the end of the very first non-zero wait. A wrong exponent or mask shows as a `drawnSlots` value at or above 2^k, or as the top half of the range never being reached across repeated draws, which the cheap full-duplex draws expose within a few hundred clocks. A broken control state shows as `busy` dropping without `done`, a `done` that lasts more than one clock, or a start taken while busy changing `drawnSlots`.

// File: rtl/cbk_pkg.sv
package cbk_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;  // capture a new draw and restart the counters
    logic tick;  // advance the bit/slot counters by one bit time
  } cbkStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } cbkState_t;

endpackage

// File: rtl/cbk_datapath.sv
module cbk_datapath
  import cbk_pkg::*;
#(
  parameter int ATTEMPT_W = 5,
  parameter int LIMIT_C0  = 10,
  parameter int LIMIT_C1  = 8,
  parameter int LIMIT_C2  = 4,
  parameter int LIMIT_C3  = 1,
  parameter int SLOT_LO   = 512,
  parameter int SLOT_HI   = 4096,
  parameter int LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int MAX_EXP  = LIMIT_C0,
  localparam int EXP_W    = $clog2(MAX_EXP + 1),
  localparam int BIT_W    = (SLOT_HI > 1) ? $clog2(SLOT_HI) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cbkStrobes_t          strobes,
  input  logic [ATTEMPT_W-1:0] attempt,
  input  logic [1:0]           limitCode,
  input  logic                 gigMode,
  output logic                 drawZero,
  output logic                 lastTick,
  output logic [MAX_EXP-1:0]   drawnSlots
);

  localparam logic [BIT_W-1:0] LO_LAST = BIT_W'(SLOT_LO - 1);
  localparam logic [BIT_W-1:0] HI_LAST = BIT_W'(SLOT_HI - 1);

  // ---------------- free-running pseudo-random source ----------------
  logic [LFSR_W-1:0] lfsr;

  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= LFSR_SEED;
    else       lfsr <= (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);
  end

  // ---------------- exponent clamp ----------------
  logic [EXP_W-1:0]     clampVal;
  logic [ATTEMPT_W-1:0] clampWide;
  logic [EXP_W-1:0]     expK;

  always_comb begin
    unique case (limitCode)
      2'd0:    clampVal = EXP_W'(LIMIT_C0);
      2'd1:    clampVal = EXP_W'(LIMIT_C1);
      2'd2:    clampVal = EXP_W'(LIMIT_C2);
      default: clampVal = EXP_W'(LIMIT_C3);
    endcase
  end

  assign clampWide = ATTEMPT_W'(clampVal);
  assign expK      = (attempt > clampWide) ? clampVal : EXP_W'(attempt);

  // ---------------- mask and draw ----------------
  logic [MAX_EXP-1:0] drawMask;
  logic [MAX_EXP-1:0] drawNow;

  for (genvar i = 0; i < MAX_EXP; i++) begin : g_mask
    assign drawMask[i] = (expK > EXP_W'(i));
  end

  assign drawNow  = lfsr[MAX_EXP-1:0] & drawMask;
  assign drawZero = (drawNow == '0);

  // ---------------- captured draw and counters ----------------
  logic [MAX_EXP-1:0] drawnQ;
  logic [EXP_W-1:0]   expKQ;
  logic [MAX_EXP-1:0] slotsLeft;
  logic [BIT_W-1:0]   bitCnt;
  logic [BIT_W-1:0]   slotLastQ;
  logic               slotWrap;

  assign slotWrap = (bitCnt == slotLastQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drawnQ    <= '0;
      expKQ     <= '0;
      slotsLeft <= '0;
      bitCnt    <= '0;
      slotLastQ <= LO_LAST;
    end else if (strobes.load) begin
      drawnQ    <= drawNow;
      expKQ     <= expK;
      slotsLeft <= drawNow;
      bitCnt    <= '0;
      slotLastQ <= gigMode ? HI_LAST : LO_LAST;
    end else if (strobes.tick) begin
      if (slotWrap) begin
        bitCnt    <= '0;
        slotsLeft <= slotsLeft - 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign lastTick   = (slotsLeft == MAX_EXP'(1)) && slotWrap;
  assign drawnSlots = drawnQ;

  // ---------------- assertions ----------------
  AST_DRAW_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> ((drawnSlots >> expKQ) == '0));  // R2

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick |-> (slotsLeft != '0));  // R4

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= slotLastQ);  // R3

  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);  // R2

endmodule

// File: rtl/cbk_control.sv
module cbk_control
  import cbk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        halfDuplex,
  input  logic        bitTick,
  input  logic        drawZero,
  input  logic        lastTick,
  output cbkStrobes_t strobes,
  output logic        done,
  output logic        busy
);

  cbkState_t state;
  cbkState_t stateNext;
  logic      doneNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          if (!halfDuplex || drawZero) doneNext  = 1'b1;
          else                         stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (bitTick) begin
          strobes.tick = 1'b1;
          if (lastTick) begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  assign busy = (state == ST_WAIT);

  // ---------------- assertions ----------------
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R10

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);  // R10

  AST_FD_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !halfDuplex) |=> (done && !busy));  // R6

  AST_ZERO_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && drawZero) |=> (done && !busy));  // R5

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !bitTick) |=> (busy && !done));  // R8

endmodule

// File: rtl/collision_backoff.sv
module collision_backoff
  import cbk_pkg::*;
#(
  parameter int ATTEMPT_W = 5,
  parameter int LIMIT_C0  = 10,
  parameter int LIMIT_C1  = 8,
  parameter int LIMIT_C2  = 4,
  parameter int LIMIT_C3  = 1,
  parameter int SLOT_LO   = 512,
  parameter int SLOT_HI   = 4096,
  localparam int MAX_EXP  = LIMIT_C0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ATTEMPT_W-1:0] attempt,
  input  logic [1:0]           limitCode,
  input  logic                 gigMode,
  input  logic                 halfDuplex,
  input  logic                 bitTick,
  output logic                 done,
  output logic                 busy,
  output logic [MAX_EXP-1:0]   drawnSlots
);

  cbkStrobes_t strobes;
  logic        drawZero;
  logic        lastTick;

  cbk_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .halfDuplex (halfDuplex),
    .bitTick    (bitTick),
    .drawZero   (drawZero),
    .lastTick   (lastTick),
    .strobes    (strobes),
    .done       (done),
    .busy       (busy)
  );

  cbk_datapath #(
    .ATTEMPT_W (ATTEMPT_W),
    .LIMIT_C0  (LIMIT_C0),
    .LIMIT_C1  (LIMIT_C1),
    .LIMIT_C2  (LIMIT_C2),
    .LIMIT_C3  (LIMIT_C3),
    .SLOT_LO   (SLOT_LO),
    .SLOT_HI   (SLOT_HI)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .attempt    (attempt),
    .limitCode  (limitCode),
    .gigMode    (gigMode),
    .drawZero   (drawZero),
    .lastTick   (lastTick),
    .drawnSlots (drawnSlots)
  );

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(drawnSlots));  // R7

endmodule

// File: tb/collision_backoff_test.sv
module collision_backoff_test;

  localparam int ATTEMPT_W = 5;
  localparam int SLOT_LO   = 4;
  localparam int SLOT_HI   = 8;
  localparam int MAX_EXP   = 10;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 start;
  logic [ATTEMPT_W-1:0] attempt;
  logic [1:0]           limitCode;
  logic                 gigMode;
  logic                 halfDuplex;
  logic                 bitTick;
  logic                 done;
  logic                 busy;
  logic [MAX_EXP-1:0]   drawnSlots;

  always #2 clk = ~clk;  // 250 MHz

  collision_backoff #(
    .ATTEMPT_W (ATTEMPT_W),
    .SLOT_LO   (SLOT_LO),
    .SLOT_HI   (SLOT_HI)
  ) uut (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .attempt    (attempt),
    .limitCode  (limitCode),
    .gigMode    (gigMode),
    .halfDuplex (halfDuplex),
    .bitTick    (bitTick),
    .done       (done),
    .busy       (busy),
    .drawnSlots (drawnSlots)
  );

  int testsRun    = 0;
  int testsFailed = 0;
  bit benchDone   = 1'b0;

  function automatic int clampFor(int code);
    case (code)
      0:       return 10;
      1:       return 8;
      2:       return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int expFor(int code, int n);
    return (n < clampFor(code)) ? n : clampFor(code);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Many full-duplex draws for one (code, n): range and reach of r.
  task automatic runStats(int code, int n);
    int k     = expFor(code, n);
    int maxR  = 0;
    for (int d = 0; d < 32; d++) begin
      @(negedge clk);
      limitCode = 2'(code); attempt = ATTEMPT_W'(n);
      halfDuplex = 1'b0; gigMode = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done && !busy, "R6 full-duplex immediate done", int'(done), 1);
      check(int'(drawnSlots) < (1 << k), "R2 draw below 2^k", int'(drawnSlots), (1 << k) - 1);
      if (int'(drawnSlots) > maxR) maxR = int'(drawnSlots);
    end
    if (k == 0) check(maxR == 0, "R1 exponent zero gives r=0", maxR, 0);
    else        check(maxR >= (1 << (k - 1)), "R1 upper half of 2^k reached", maxR, 1 << (k - 1));
  endtask

  // One timed wait. tickGap=0 ticks every cycle, else one tick per tickGap+1 cycles.
  task automatic runDraw(int code, int n, bit gig, bit hd, int tickGap, bit poke);
    int ticks = 0;
    int guard = 0;
    int drawn;
    int slot;
    int expected;
    bit pokeNow;
    @(negedge clk);
    limitCode = 2'(code); attempt = ATTEMPT_W'(n);
    gigMode = gig; halfDuplex = hd; start = 1'b1;
    bitTick = 1'b1;  // idle tick, must not count (R8)
    @(negedge clk);
    start = 1'b0;
    drawn = int'(drawnSlots);
    slot  = gig ? SLOT_HI : SLOT_LO;
    expected = hd ? drawn * slot : 0;
    pokeNow  = poke && (expected > 4);
    check(drawn < (1 << expFor(code, n)), "R2 draw below 2^k", drawn, (1 << expFor(code, n)) - 1);
    if (hd && drawn == 0) check(done && !busy, "R5 zero draw immediate done", int'(done), 1);
    while (!done && guard < 20000) begin
      if (!busy) begin
        check(1'b0, "R4 busy dropped without done", 0, 1);
        break;
      end
      bitTick = (tickGap == 0) || ((guard % (tickGap + 1)) == 0);
      if (bitTick) ticks++;
      if (pokeNow && guard == 2) begin
        start = 1'b1; limitCode = 2'd3; attempt = '0; gigMode = ~gig;
      end else begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    bitTick = 1'b0; start = 1'b0;
    check(done, "R4 done reached", int'(done), 1);
    check(ticks == expected, "R4 delay equals r x slot (R3 slot length)", ticks, expected);
    check(!busy, "R10 busy low with done", int'(busy), 0);
    if (pokeNow) check(int'(drawnSlots) == drawn, "R7 start while busy ignored", int'(drawnSlots), drawn);
    @(negedge clk);
    check(!done, "R10 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!benchDone) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; start = 1'b0; attempt = '0; limitCode = '0;
    gigMode = 1'b0; halfDuplex = 1'b1; bitTick = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy, "R9 reset busy", int'(busy), 0);
    check(!done, "R9 reset done", int'(done), 0);
    check(drawnSlots == '0, "R9 reset drawnSlots", int'(drawnSlots), 0);
    rstN = 1'b1;

    // R1/R2: exponent clamp for every code over attempts 0..12
    for (int code = 0; code < 4; code++)
      for (int n = 0; n <= 12; n++)
        runStats(code, n);

    // R5: exponent 0 forces r = 0 in half-duplex
    runDraw(0, 0, 1'b0, 1'b1, 0, 1'b0);
    runDraw(2, 0, 1'b1, 1'b1, 2, 1'b0);

    // R6: full-duplex with a wide exponent
    runDraw(0, 10, 1'b1, 1'b0, 0, 1'b0);

    // R3/R4/R8: timed waits for each code, both speeds, with and without tick gaps
    for (int code = 0; code < 4; code++) begin
      int n;
      case (code)
        0:       n = 5;
        1:       n = 9;
        2:       n = 7;
        default: n = 9;
      endcase
      for (int g = 0; g < 2; g++)
        for (int d = 0; d < 4; d++)
          runDraw(code, n, g[0], 1'b1, (d % 2) * 2, 1'b0);
    end

    // R7: start pulses while counting
    for (int d = 0; d < 4; d++) runDraw(0, 6, 1'b0, 1'b1, 1, 1'b1);

    // Widest exponent once
    runDraw(0, 10, 1'b0, 1'b1, 0, 1'b0);

    benchDone = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule